// File: doc/BRIEF.md
# Compact 16-bit Instruction Execution Core

This block executes one fixed-width 16-bit instruction per clock. It holds an 8-bit datapath with sixteen general registers, an arithmetic/logic unit, a single zero flag, a 10-bit program counter and a one-entry link register used for subroutine calls. Four 8-bit input ports can be read into registers and four registered 8-bit output ports can be written from registers.

Instructions come from an external synchronous ROM. The core drives the address of the *next* instruction on `fetch_addr_o`. The ROM registers that address at the clock edge and presents the word on `instr_i` during the following cycle, which is the cycle in which the core executes it. An external sequencer may take over control flow. When `redirect_i` is high, `redirect_pc_i` becomes the next program counter. The instruction in the current cycle still completes.

Opcodes vary in length. The top nibble picks the instruction class. Control transfers and port accesses use a 6-bit opcode. Arithmetic and immediate loads use a 4-bit opcode followed by 4-bit register fields.

Top module: `core16_exec`

## Requirements
- R1: While reset is low, `fetch_addr_o` is 0 and every output port reads 0. Reset also clears the program counter, the zero flag and the link register.
- R2: `fetch_addr_o` always shows the address that becomes the program counter at the next edge. After reset is released, the first instruction executed is at address 0 and the next fetch address is 1.
- R3: Word `0001 iiii iiii dddd` loads the 8-bit immediate in bits 11:4 into the register named by bits 3:0.
- R4: Two-operand operations take source A from bits 11:8, source B from bits 7:4 and the destination from bits 3:0. Top nibble 1010 gives A+B, 1011 gives A-B, 1100 gives A&B and 1101 gives A|B. Results wrap modulo 256.
- R5: Top nibble 1000 copies source A to the destination. Top nibble 1001 writes the bitwise inverse of A. Top nibble 1110 writes the two's-complement negation of bits 11:8 when that field is non-zero, and otherwise of bits 7:4.
- R6: Register 0 always reads as 0, and any write to it is discarded.
- R7: The zero flag takes (result == 0) only for top nibbles 1000 to 1110. Every other instruction leaves the flag unchanged.
- R8: Bits 15:10 equal to 000001 jump to the absolute target in bits 9:0. Bits 15:10 equal to 000010 jump only when the zero flag is 1, and 000011 jump only when it is 0. Bits 15:10 equal to 000000 do nothing. A jump that is not taken falls through to PC+1.
- R9: Bits 15:10 equal to 001000 save PC+1 in the link register and jump to bits 9:0. Bits 15:10 equal to 001001 set the next PC to the link register.
- R10: Bits 15:10 equal to 001010 copy input port bits 9:8 (port n occupies bits 8n+7:8n) to the register named by bits 3:0. Bits 15:10 equal to 001011 copy the register named by bits 7:4 into output port bits 9:8. Output ports change only on such a write.
- R11: Top nibbles 0011 to 0111 and 1111 behave as no-ops. They write no register and no port and leave the flag unchanged.
- R12: When `redirect_i` is high, the next PC is `redirect_pc_i`, whatever the current instruction would select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word returned by the ROM for the current PC |
| fetch_addr_o | output | 10 | Address of the next instruction, for the ROM to register |
| in_ports_i | input | 32 | Four 8-bit input ports, port n in bits 8n+7:8n |
| out_ports_o | output | 32 | Four registered 8-bit output ports, same packing |
| redirect_i | input | 1 | Forces the next PC to `redirect_pc_i` |
| redirect_pc_i | input | 10 | Target used when a redirect is requested |

## Verification
A scoreboard predicts every output-port write from small programs loaded into a modelled synchronous ROM. One program is straight-line arithmetic, including wrap-around and both source fields of negation, so it separates the operations and their field decoding. Another is a countdown loop followed by taken and untaken conditional branches, with a flag-neutral load between the compare and the branch; it tells flag updating apart from flag holding. Further programs cover register-zero writes, undefined opcodes and a call/return pair with port reads. A last program redirects out of a self-loop, which shows that the external override wins over a jump.

// File: rtl/core16_pkg.sv
package core16_pkg;
  localparam int INSTR_W = 16;
  localparam int PC_W    = 10;
  localparam int RADDR_W = 4;
  localparam int NREGS   = 1 << RADDR_W;
  localparam int PSEL_W  = 2;
  localparam int NPORTS  = 1 << PSEL_W;
  localparam int IMM_W   = 8;

  typedef enum logic [3:0] {
    OP_NOP, OP_JMP, OP_JZ, OP_JNZ, OP_LDI, OP_JAL, OP_RET, OP_PRD,
    OP_PWR, OP_MOV, OP_NOT, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NEG
  } op_e;

  typedef struct packed {
    op_e                op;
    logic [RADDR_W-1:0] ra;
    logic [RADDR_W-1:0] rb;
    logic [RADDR_W-1:0] rd;
    logic [IMM_W-1:0]   imm;
    logic [PC_W-1:0]    target;
    logic [PSEL_W-1:0]  psel;
    logic               alu_class;
    logic               wr_en;
  } dec_t;
endpackage

// File: rtl/core16_decode.sv
module core16_decode import core16_pkg::*; (
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec        = '0;
    dec.op     = OP_NOP;
    dec.ra     = instr[11:8];
    dec.rb     = instr[7:4];
    dec.rd     = instr[3:0];
    dec.imm    = instr[11:4];
    dec.target = instr[9:0];
    dec.psel   = instr[9:8];
    case (instr[15:12])
      4'b0000: begin
        case (instr[11:10])
          2'b00:   dec.op = OP_NOP;
          2'b01:   dec.op = OP_JMP;
          2'b10:   dec.op = OP_JZ;
          default: dec.op = OP_JNZ;
        endcase
      end
      4'b0001: begin
        dec.op    = OP_LDI;
        dec.wr_en = 1'b1;
      end
      4'b0010: begin
        case (instr[11:10])
          2'b00: dec.op = OP_JAL;
          2'b01: dec.op = OP_RET;
          2'b10: begin
            dec.op    = OP_PRD;
            dec.wr_en = 1'b1;
          end
          default: dec.op = OP_PWR;
        endcase
      end
      4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101, 4'b1110: begin
        dec.alu_class = 1'b1;
        dec.wr_en     = 1'b1;
        case (instr[14:12])
          3'b000:  dec.op = OP_MOV;
          3'b001:  dec.op = OP_NOT;
          3'b010:  dec.op = OP_ADD;
          3'b011:  dec.op = OP_SUB;
          3'b100:  dec.op = OP_AND;
          3'b101:  dec.op = OP_OR;
          default: begin
            dec.op = OP_NEG;
            // negation takes whichever source field is populated
            dec.ra = (instr[11:8] != '0) ? instr[11:8] : instr[7:4];
          end
        endcase
      end
      default: dec.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/core16_regfile.sv
module core16_regfile import core16_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [RADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0]  rdata_a,
  input  logic [RADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0]  rdata_b
);
  logic [NREGS*DATA_W-1:0] flat;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign flat[0 +: DATA_W] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                              q <= '0;
        else if (we && waddr == RADDR_W'(i))     q <= wdata;
      end
      assign flat[i*DATA_W +: DATA_W] = q;
    end
  end

  assign rdata_a = flat[raddr_a*DATA_W +: DATA_W];
  assign rdata_b = flat[raddr_b*DATA_W +: DATA_W];
endmodule

// File: rtl/core16_alu.sv
module core16_alu import core16_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              zero
);
  always_comb begin
    case (op)
      OP_MOV:  res = a;
      OP_NOT:  res = ~a;
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_NEG:  res = '0 - a;
      default: res = '0;
    endcase
    zero = (res == '0);
  end
endmodule

// File: rtl/core16_ports.sv
module core16_ports import core16_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [PSEL_W-1:0]        wsel,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [PSEL_W-1:0]        rsel,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NPORTS*DATA_W-1:0] in_flat,
  output logic [NPORTS*DATA_W-1:0] out_flat
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_out
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (we && wsel == PSEL_W'(p))   q <= wdata;
    end
    assign out_flat[p*DATA_W +: DATA_W] = q;
  end

  assign rdata = in_flat[rsel*DATA_W +: DATA_W];

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(out_flat));
endmodule

// File: rtl/core16_exec.sv
module core16_exec import core16_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [INSTR_W-1:0]       instr_i,
  output logic [PC_W-1:0]          fetch_addr_o,
  input  logic [NPORTS*DATA_W-1:0] in_ports_i,
  output logic [NPORTS*DATA_W-1:0] out_ports_o,
  input  logic                     redirect_i,
  input  logic [PC_W-1:0]          redirect_pc_i
);
  dec_t              dec;
  logic [PC_W-1:0]   pc_q, link_q, pc_inc, next_pc;
  logic              zflag_q;
  logic [DATA_W-1:0] src_a, src_b, alu_res, port_rd, wdata;
  logic              alu_zero;

  core16_decode u_dec (.instr(instr_i), .dec(dec));

  core16_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(dec.wr_en), .waddr(dec.rd), .wdata(wdata),
    .raddr_a(dec.ra), .rdata_a(src_a), .raddr_b(dec.rb), .rdata_b(src_b));

  core16_alu #(.DATA_W(DATA_W)) u_alu (
    .op(dec.op), .a(src_a), .b(src_b), .res(alu_res), .zero(alu_zero));

  core16_ports #(.DATA_W(DATA_W)) u_ports (
    .clk(clk), .rst_n(rst_n), .we(dec.op == OP_PWR), .wsel(dec.psel),
    .wdata(src_b), .rsel(dec.psel), .rdata(port_rd),
    .in_flat(in_ports_i), .out_flat(out_ports_o));

  always_comb begin
    case (dec.op)
      OP_LDI:  wdata = DATA_W'(dec.imm);
      OP_PRD:  wdata = port_rd;
      default: wdata = alu_res;
    endcase
  end

  always_comb begin
    pc_inc  = pc_q + PC_W'(1);
    next_pc = pc_inc;
    case (dec.op)
      OP_JMP, OP_JAL: next_pc = dec.target;
      OP_JZ:          if (zflag_q)  next_pc = dec.target;
      OP_JNZ:         if (!zflag_q) next_pc = dec.target;
      OP_RET:         next_pc = link_q;
      default: ;
    endcase
    if (redirect_i) next_pc = redirect_pc_i;
  end

  assign fetch_addr_o = rst_n ? next_pc : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      link_q  <= '0;
      zflag_q <= 1'b0;
    end else begin
      pc_q <= next_pc;
      if (dec.op == OP_JAL) link_q  <= pc_inc;
      if (dec.alu_class)    zflag_q <= alu_zero;
    end
  end

  p_fetch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc_q == $past(fetch_addr_o));
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.alu_class |=> $stable(zflag_q));
  p_link_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.op == OP_JAL) |=> link_q == PC_W'($past(pc_q) + PC_W'(1)));
  p_redirect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> pc_q == $past(redirect_pc_i));
endmodule

// File: tb/core16_exec_bench.sv
`timescale 1ns/1ps
module core16_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [9:0]  fetch;
  logic [31:0] in_ports = 32'h44332211;
  logic [31:0] outs;
  logic        redir = 1'b0;
  logic [9:0]  redir_pc = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int wa = 0;
  logic [15:0] rom [1024];

  int          q_port[$];
  logic [7:0]  q_val[$];
  string       q_tag[$];
  logic [7:0]  prev [4];
  logic [7:0]  cur;
  int          ep;
  logic [7:0]  ev;
  string       et;

  always #2.5 clk = ~clk;

  core16_exec u_core16_exec (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .fetch_addr_o(fetch),
    .in_ports_i(in_ports), .out_ports_o(outs),
    .redirect_i(redir), .redirect_pc_i(redir_pc));

  always @(posedge clk) instr <= rom[fetch];

  // monitor: every port change must match the head of the scoreboard
  always @(negedge clk) begin
    for (int p = 0; p < 4; p++) begin
      cur = outs[p*8 +: 8];
      if (rst_n && cur != prev[p]) begin
        n_cmp++;
        if (q_port.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected write: port %0d actual %02h expected none", p, cur);
        end else begin
          ep = q_port.pop_front(); ev = q_val.pop_front(); et = q_tag.pop_front();
          if (ep != p || ev != cur) begin
            n_bad++;
            $display("FAIL %s: actual port %0d=%02h expected port %0d=%02h", et, p, cur, ep, ev);
          end
        end
      end
      prev[p] = cur;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_w(int p, int v, string tag);
    q_port.push_back(p); q_val.push_back(v[7:0]); q_tag.push_back(tag);
  endtask

  function automatic logic [15:0] f_ldi(int imm, int rd);
    return {4'b0001, imm[7:0], rd[3:0]};
  endfunction
  function automatic logic [15:0] f_alu(logic [3:0] op, int a, int b, int d);
    return {op, a[3:0], b[3:0], d[3:0]};
  endfunction
  function automatic logic [15:0] f_ctl(logic [5:0] code, int tgt);
    return {code, tgt[9:0]};
  endfunction
  function automatic logic [15:0] f_prd(int sel, int rd);
    return {6'b001010, sel[1:0], 4'b0000, rd[3:0]};
  endfunction
  function automatic logic [15:0] f_pwr(int sel, int rs);
    return {6'b001011, sel[1:0], rs[3:0], 4'b0000};
  endfunction

  task automatic put(logic [15:0] w);
    rom[wa] = w; wa++;
  endtask

  task automatic load_at(int a);
    wa = a;
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 1024; i++) rom[i] = 16'h0000;
    wa = 0;
  endtask

  task automatic reset_core();
    @(negedge clk);
    rst_n = 1'b0; redir = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 fetch in reset", fetch, 0);
    chk("R1 ports in reset", outs, 0);
    rst_n = 1'b1;
    #0.5;
    chk("R2 first fetch", fetch, 1);
  endtask

  task automatic finish_prog(int cycles, string tag);
    repeat (cycles) @(negedge clk);
    chk({tag, " scoreboard drained"}, q_port.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R3 R4 R5: straight-line arithmetic
    clear_rom();
    put(f_ldi(5, 1)); put(f_ldi(3, 2));
    put(f_alu(4'b1010, 1, 2, 3)); put(f_pwr(0, 3));
    put(f_alu(4'b1011, 1, 2, 4)); put(f_pwr(1, 4));
    put(f_ldi(8'h0C, 5)); put(f_ldi(8'h0A, 6));
    put(f_alu(4'b1100, 5, 6, 7)); put(f_pwr(2, 7));
    put(f_alu(4'b1101, 5, 6, 8)); put(f_pwr(3, 8));
    put(f_alu(4'b1001, 1, 0, 9)); put(f_pwr(0, 9));
    put(f_alu(4'b1110, 2, 0, 10)); put(f_pwr(1, 10));
    put(f_alu(4'b1110, 0, 1, 11)); put(f_pwr(2, 11));
    put(f_alu(4'b1000, 6, 0, 12)); put(f_pwr(3, 12));
    put(f_ldi(8'hC8, 13)); put(f_alu(4'b1010, 13, 13, 14)); put(f_pwr(0, 14));
    put(f_ctl(6'b000001, 23));
    expect_w(0, 8'h08, "R4 add");  expect_w(1, 8'h02, "R4 sub");
    expect_w(2, 8'h08, "R4 and");  expect_w(3, 8'h0E, "R4 or");
    expect_w(0, 8'hFA, "R5 not");  expect_w(1, 8'hFD, "R5 neg A field");
    expect_w(2, 8'hFB, "R5 neg B field"); expect_w(3, 8'h0A, "R5 mov");
    expect_w(0, 8'h90, "R4 add wrap");
    reset_core();
    finish_prog(50, "R3");

    // R6: register zero
    clear_rom();
    put(f_ldi(7, 1)); put(f_pwr(0, 1));
    put(f_ldi(8'h55, 0)); put(f_pwr(0, 0));
    put(f_alu(4'b1010, 0, 1, 2)); put(f_pwr(1, 2));
    put(f_ctl(6'b000001, 6));
    expect_w(0, 7, "R6 setup"); expect_w(0, 0, "R6 write discarded");
    expect_w(1, 7, "R6 reads zero");
    reset_core();
    finish_prog(30, "R6");

    // R7 R8 R11: loop, branches, flag hold, undefined opcodes
    clear_rom();
    put(f_ldi(4, 1)); put(f_ldi(1, 2));
    put(f_alu(4'b1011, 1, 2, 1)); put(f_pwr(0, 1)); put(f_ctl(6'b000011, 2));
    put(f_alu(4'b1011, 0, 0, 0)); put(f_ldi(9, 3)); put(f_ctl(6'b000010, 9));
    put(f_pwr(1, 3));
    put(f_ldi(8'h22, 4)); put(f_pwr(1, 4));
    put(f_ldi(1, 5)); put(f_alu(4'b1000, 5, 0, 5)); put(f_ctl(6'b000010, 17));
    put(f_pwr(2, 5)); put(f_ldi(8'h33, 7)); put(f_ctl(6'b000001, 20));
    put(f_ldi(8'hEE, 6)); put(f_pwr(2, 6)); put(f_ctl(6'b000001, 19));
    put(16'hF707); put(16'h3A07); put(f_pwr(3, 7)); put(f_ctl(6'b000001, 23));
    expect_w(0, 3, "R8 jnz loop"); expect_w(0, 2, "R8 jnz loop");
    expect_w(0, 1, "R8 jnz loop"); expect_w(0, 0, "R8 jnz exit");
    expect_w(1, 8'h22, "R7 flag held over load, jz taken");
    expect_w(2, 1, "R8 jz not taken");
    expect_w(3, 8'h33, "R11 undefined opcodes are no-ops");
    reset_core();
    finish_prog(60, "R8");

    // R9 R10: call/return and port reads
    clear_rom();
    put(f_prd(2, 1)); put(f_pwr(0, 1)); put(f_ctl(6'b001000, 10));
    put(f_pwr(1, 2)); put(f_prd(0, 3)); put(f_pwr(2, 3)); put(f_ctl(6'b000001, 6));
    load_at(10); put(f_ldi(8'h66, 2)); put(16'h2400);
    expect_w(0, 8'h33, "R10 read port 2"); expect_w(1, 8'h66, "R9 return to PC+1");
    expect_w(2, 8'h11, "R10 read port 0");
    reset_core();
    finish_prog(30, "R9");

    // R12: redirect out of a self-loop
    clear_rom();
    put(f_ldi(1, 1)); put(f_pwr(0, 1)); put(f_ctl(6'b000001, 2));
    load_at(10'h40); put(f_ldi(8'h77, 2)); put(f_pwr(1, 2)); put(f_ctl(6'b000001, 10'h42));
    expect_w(0, 1, "R12 before redirect"); expect_w(1, 8'h77, "R12 redirected code");
    reset_core();
    repeat (10) @(negedge clk);
    chk("R8 self-loop fetch", fetch, 2);
    redir_pc = 10'h40; redir = 1'b1;
    #0.5;
    chk("R12 fetch follows redirect", fetch, 10'h40);
    @(negedge clk);
    redir = 1'b0;
    finish_prog(15, "R12");
    chk("R8 parked in redirected loop", fetch, 10'h42);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule